// File: doc/BRIEF.md
# Copy-Engine Ring Index and Interrupt Controller

This block keeps the ring bookkeeping for one copy-engine channel. It tracks two descriptor rings: a source ring that software fills with descriptors to send, and a destination ring that software fills with empty receive buffers. Each ring has a power-of-two number of entries. Software moves each ring's write index through a 32-bit register bus. The data-moving engine reports each descriptor it finishes with a one-cycle strobe, and the controller then advances that ring's read index. All index arithmetic wraps on the ring size.

From each ring's fill level (read-to-write distance) the controller sets sticky watermark flags against programmable high and low thresholds. It also sets a copy-complete flag and ring-overflow flags, and latches fault pulses from the engine into error flags. Two enable registers gate the two status registers onto a single interrupt line. A halt command stops the engine. Its status bit goes high only once no descriptor is in flight, and the engine's strobes are ignored while it is high.

Top module: `ce_ring_ctrl`

## Requirements
- R1: After reset every index, threshold, enable, status and command register reads 0, `irq_o` is 0 and `halted_o` is 0.
- R2: Writing 0x3C (source) or 0x40 (destination) stores bits [IDX_W-1:0] as that ring's write index, and the value reads back. Each accepted consume strobe advances the ring's read index to (idx+1) AND (entries-1). The source read index reads at 0x44 and the destination read index at 0x48.
- R3: A consume strobe is ignored while its ring is empty (read index equals write index). It changes no index and sets no flag.
- R4: A write-index write whose advance (new-old) AND (entries-1) is larger than the free space (entries-1-fill) is ignored. It sets overflow status: bit5 at 0x38 for the source ring, bit6 for the destination ring.
- R5: Each accepted source consume sets copy-complete, bit0 at 0x30.
- R6: Registers 0x4C (source) and 0x50 (destination) hold a low threshold in [31:16] and a high threshold in [15:0]. A fill above the high threshold sets bit1 (source) or bit3 (destination) at 0x30. A fill below the low threshold sets bit2 (source) or bit4 (destination). The flags are set on the clock edge after the fill changes.
- R7: Status bits at 0x30 and 0x38 are sticky. Writing 1 clears a bit and writing 0 leaves it. When a set condition and a clear arrive in the same cycle, the set wins.
- R8: `irq_o` is high exactly when some bit of 0x30 AND 0x2C (bits [4:0]) or some bit of 0x38 AND 0x34 (bits [10:5]) is set.
- R9: Pulses on `fault_i[0..3]` set bits 7, 8, 9 and 10 of 0x38 (destination max-length, source length, destination address, bus error), one edge after the pulse.
- R10: Bit0 of 0x18 requests halt, and bit3 reads the halt status, also driven on `halted_o`. The status sets on the edge after the request is registered with `busy_i` low, and stays 0 while `busy_i` is high. It clears on the edge after the request is registered as removed.
- R11: While halt status is set, consume strobes on both rings are ignored.
- R12: Writes to 0x44 and 0x48 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| src_done_i | input | 1 | Engine finished one source descriptor |
| dst_done_i | input | 1 | Engine filled one destination descriptor |
| fault_i | input | 4 | Fault pulses: dst max-length, src length, dst address, bus |
| busy_i | input | 1 | A descriptor is in flight |
| halted_o | output | 1 | Halt status |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the engine raises done strobes and fault pulses only as single-cycle pulses on clock edges, and that software puts at most one register access on the bus per cycle. The directed stimulus drives every input at the falling edge and holds each strobe for exactly one cycle. It changes `busy_i` only between bus accesses. It also sends consume strobes into empty rings and while halted on purpose, because those are legal inputs that the design must ignore.

// File: rtl/ce_ring_pkg.sv
package ce_ring_pkg;
  localparam logic [7:0] ADDR_CMD     = 8'h18;
  localparam logic [7:0] ADDR_HOST_IE = 8'h2C;
  localparam logic [7:0] ADDR_HOST_IS = 8'h30;
  localparam logic [7:0] ADDR_MISC_IE = 8'h34;
  localparam logic [7:0] ADDR_MISC_IS = 8'h38;
  localparam logic [7:0] ADDR_SRC_WR  = 8'h3C;
  localparam logic [7:0] ADDR_DST_WR  = 8'h40;
  localparam logic [7:0] ADDR_SRC_RD  = 8'h44;
  localparam logic [7:0] ADDR_DST_RD  = 8'h48;
  localparam logic [7:0] ADDR_SRC_WM  = 8'h4C;
  localparam logic [7:0] ADDR_DST_WM  = 8'h50;

  localparam int HOST_W   = 5;
  localparam int MISC_W   = 6;
  localparam int MISC_LSB = 5;
  localparam int THR_W    = 16;
  localparam int HALT_REQ_BIT = 0;
  localparam int HALT_ST_BIT  = 3;

  typedef struct packed {
    logic [THR_W-1:0] lo;
    logic [THR_W-1:0] hi;
  } wm_t;
endpackage

// File: rtl/ce_ring_track.sv
module ce_ring_track
  import ce_ring_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_req_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             consume_i,
  input  wm_t              wm_i,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             ovf_o,
  output logic             accept_o,
  output logic             hi_o,
  output logic             lo_o
);
  localparam logic [IDX_W-1:0] MASK = IDX_W'(ENTRIES - 1);

  function automatic logic [IDX_W-1:0] ring_dist(logic [IDX_W-1:0] from_i, logic [IDX_W-1:0] to_i);
    return (to_i - from_i) & MASK;
  endfunction

  logic [IDX_W-1:0] wr_q, rd_q, fill, space, adv;

  assign fill  = ring_dist(rd_q, wr_q);
  assign space = MASK - fill;
  assign adv   = ring_dist(wr_q, wr_idx_i);

  assign ovf_o    = wr_req_i && (adv > space);
  assign accept_o = consume_i && (fill != '0);
  assign hi_o     = THR_W'(fill) > wm_i.hi;
  assign lo_o     = THR_W'(fill) < wm_i.lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      if (wr_req_i && !ovf_o) wr_q <= wr_idx_i;
      if (accept_o)           rd_q <= (rd_q + 1'b1) & MASK;
    end
  end

  assign wr_idx_o = wr_q;
  assign rd_idx_o = rd_q;
endmodule

// File: rtl/ce_w1c_reg.sv
module ce_w1c_reg #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set wins
  end
endmodule

// File: rtl/ce_halt_ctrl.sv
module ce_halt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic halted_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      halted_o <= 1'b0;
    else if (!req_i)  halted_o <= 1'b0;
    else if (!busy_i) halted_o <= 1'b1;
  end
endmodule

// File: rtl/ce_ring_ctrl.sv
module ce_ring_ctrl
  import ce_ring_pkg::*;
#(
  parameter int SRC_ENTRIES = 16,
  parameter int DST_ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        src_done_i,
  input  logic        dst_done_i,
  input  logic [3:0]  fault_i,
  input  logic        busy_i,
  output logic        halted_o,
  output logic        irq_o
);
  localparam int SRC_IDX_W = $clog2(SRC_ENTRIES);
  localparam int DST_IDX_W = $clog2(DST_ENTRIES);

  logic [HOST_W-1:0]    host_ie_q, host_is, host_set, host_clr;
  logic [MISC_W-1:0]    misc_ie_q, misc_is, misc_set, misc_clr;
  logic                 halt_req_q;
  wm_t                  src_wm_q, dst_wm_q;
  logic [SRC_IDX_W-1:0] src_wr_idx, src_rd_idx;
  logic [DST_IDX_W-1:0] dst_wr_idx, dst_rd_idx;
  logic src_ovf, src_acc, src_hi, src_lo;
  logic dst_ovf, dst_acc, dst_hi, dst_lo;

  function automatic logic wr_at(logic [7:0] a);
    return reg_we_i && (reg_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_ie_q  <= '0;
      misc_ie_q  <= '0;
      halt_req_q <= 1'b0;
      src_wm_q   <= '0;
      dst_wm_q   <= '0;
    end else begin
      if (wr_at(ADDR_HOST_IE)) host_ie_q  <= reg_wdata_i[HOST_W-1:0];
      if (wr_at(ADDR_MISC_IE)) misc_ie_q  <= reg_wdata_i[MISC_LSB+:MISC_W];
      if (wr_at(ADDR_CMD))     halt_req_q <= reg_wdata_i[HALT_REQ_BIT];
      if (wr_at(ADDR_SRC_WM))  src_wm_q   <= reg_wdata_i;
      if (wr_at(ADDR_DST_WM))  dst_wm_q   <= reg_wdata_i;
    end
  end

  ce_ring_track #(.ENTRIES(SRC_ENTRIES), .IDX_W(SRC_IDX_W)) u_src (
    .clk_i, .rst_ni,
    .wr_req_i (wr_at(ADDR_SRC_WR)),
    .wr_idx_i (reg_wdata_i[SRC_IDX_W-1:0]),
    .consume_i(src_done_i && !halted_o),
    .wm_i     (src_wm_q),
    .wr_idx_o (src_wr_idx),
    .rd_idx_o (src_rd_idx),
    .ovf_o    (src_ovf),
    .accept_o (src_acc),
    .hi_o     (src_hi),
    .lo_o     (src_lo)
  );

  ce_ring_track #(.ENTRIES(DST_ENTRIES), .IDX_W(DST_IDX_W)) u_dst (
    .clk_i, .rst_ni,
    .wr_req_i (wr_at(ADDR_DST_WR)),
    .wr_idx_i (reg_wdata_i[DST_IDX_W-1:0]),
    .consume_i(dst_done_i && !halted_o),
    .wm_i     (dst_wm_q),
    .wr_idx_o (dst_wr_idx),
    .rd_idx_o (dst_rd_idx),
    .ovf_o    (dst_ovf),
    .accept_o (dst_acc),
    .hi_o     (dst_hi),
    .lo_o     (dst_lo)
  );

  // dst_acc only advances the index; copy-complete follows the source ring
  logic unused_dst_acc;
  assign unused_dst_acc = dst_acc;

  assign host_set = {dst_lo, dst_hi, src_lo, src_hi, src_acc};
  assign host_clr = wr_at(ADDR_HOST_IS) ? reg_wdata_i[HOST_W-1:0] : '0;
  assign misc_set = {fault_i, dst_ovf, src_ovf};
  assign misc_clr = wr_at(ADDR_MISC_IS) ? reg_wdata_i[MISC_LSB+:MISC_W] : '0;

  ce_w1c_reg #(.W(HOST_W)) u_host_is (
    .clk_i, .rst_ni, .set_i(host_set), .clr_i(host_clr), .q_o(host_is)
  );

  ce_w1c_reg #(.W(MISC_W)) u_misc_is (
    .clk_i, .rst_ni, .set_i(misc_set), .clr_i(misc_clr), .q_o(misc_is)
  );

  ce_halt_ctrl u_halt (
    .clk_i, .rst_ni, .req_i(halt_req_q), .busy_i, .halted_o
  );

  assign irq_o = |(host_is & host_ie_q) | |(misc_is & misc_ie_q);

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CMD: begin
        reg_rdata_o[HALT_REQ_BIT] = halt_req_q;
        reg_rdata_o[HALT_ST_BIT]  = halted_o;
      end
      ADDR_HOST_IE: reg_rdata_o[HOST_W-1:0]       = host_ie_q;
      ADDR_HOST_IS: reg_rdata_o[HOST_W-1:0]       = host_is;
      ADDR_MISC_IE: reg_rdata_o[MISC_LSB+:MISC_W] = misc_ie_q;
      ADDR_MISC_IS: reg_rdata_o[MISC_LSB+:MISC_W] = misc_is;
      ADDR_SRC_WR:  reg_rdata_o[SRC_IDX_W-1:0]    = src_wr_idx;
      ADDR_DST_WR:  reg_rdata_o[DST_IDX_W-1:0]    = dst_wr_idx;
      ADDR_SRC_RD:  reg_rdata_o[SRC_IDX_W-1:0]    = src_rd_idx;
      ADDR_DST_RD:  reg_rdata_o[DST_IDX_W-1:0]    = dst_rd_idx;
      ADDR_SRC_WM:  reg_rdata_o                   = src_wm_q;
      ADDR_DST_WM:  reg_rdata_o                   = dst_wm_q;
      default:      reg_rdata_o                   = '0;
    endcase
  end
endmodule

// File: rtl/ce_ring_ctrl_chk.sv
module ce_ring_ctrl_chk #(
  parameter int SRC_IDX_W = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 src_done_i,
  input logic [3:0]           fault_i,
  input logic                 busy_i,
  input logic                 halted_o,
  input logic [SRC_IDX_W-1:0] src_rd_i,
  input logic [SRC_IDX_W-1:0] src_wr_i,
  input logic [4:0]           host_is_i,
  input logic [5:0]           misc_is_i,
  input logic                 halt_req_i
);
  assert_empty_consume_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_done_i && src_rd_i == src_wr_i) |=> src_rd_i == $past(src_rd_i));

  assert_ovf_rejects_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(misc_is_i[0]) |-> src_wr_i == $past(src_wr_i));

  assert_copy_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_done_i && !halted_o && src_rd_i != src_wr_i) |=> host_is_i[0]);

  assert_bus_fault_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i[3] |=> misc_is_i[5]);

  assert_halt_drop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_req_i |=> !halted_o);

  assert_halt_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_o) |-> $past(halt_req_i && !busy_i));

  assert_halt_freeze_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && src_done_i) |=> src_rd_i == $past(src_rd_i));
endmodule

bind ce_ring_ctrl ce_ring_ctrl_chk #(.SRC_IDX_W(SRC_IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_done_i (src_done_i),
  .fault_i    (fault_i),
  .busy_i     (busy_i),
  .halted_o   (halted_o),
  .src_rd_i   (src_rd_idx),
  .src_wr_i   (src_wr_idx),
  .host_is_i  (host_is),
  .misc_is_i  (misc_is),
  .halt_req_i (halt_req_q)
);

// File: tb/sim_ce_ring_ctrl.sv
module sim_ce_ring_ctrl;
  import ce_ring_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        src_done = 1'b0, dst_done = 1'b0, busy = 1'b0;
  logic [3:0]  fault = '0;
  logic        halted, irq;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ce_ring_ctrl #(.SRC_ENTRIES(16), .DST_ENTRIES(8)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_done_i(src_done),
    .dst_done_i(dst_done), .fault_i(fault), .busy_i(busy),
    .halted_o(halted), .irq_o(irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic consume_src(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) src_done = 1'b1;
      @(negedge clk) src_done = 1'b0;
    end
  endtask

  task automatic consume_dst(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) dst_done = 1'b1;
      @(negedge clk) dst_done = 1'b0;
    end
  endtask

  task automatic pulse_fault(logic [3:0] f);
    @(negedge clk) fault = f;
    @(negedge clk) fault = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(ADDR_SRC_WR, d);  check("R1 src wr", d, 0);
    bus_rd(ADDR_DST_RD, d);  check("R1 dst rd", d, 0);
    bus_rd(ADDR_HOST_IS, d); check("R1 host status", d, 0);
    bus_rd(ADDR_MISC_IS, d); check("R1 misc status", d, 0);
    bus_rd(ADDR_CMD, d);     check("R1 cmd", d, 0);
    bus_rd(ADDR_SRC_WM, d);  check("R1 src wm", d, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 halted", 32'(halted), 0);
  endtask

  task automatic t_src_ring;
    logic [31:0] d;
    bus_wr(ADDR_SRC_WR, 5);
    bus_rd(ADDR_SRC_WR, d); check("R2 src wr readback", d, 5);
    consume_src(5);
    bus_rd(ADDR_SRC_RD, d); check("R2 src rd advance", d, 5);
    bus_rd(ADDR_HOST_IS, d); check("R5 copy complete", d & 1, 1);
    bus_wr(ADDR_HOST_IS, 32'h1F);
    bus_rd(ADDR_HOST_IS, d); check("R7 w1c clear", d, 0);
    consume_src(1);
    bus_rd(ADDR_SRC_RD, d); check("R3 empty consume rd", d, 5);
    bus_rd(ADDR_HOST_IS, d); check("R3 empty consume no flag", d & 1, 0);
    bus_wr(ADDR_SRC_WR, 3);
    consume_src(12);
    bus_rd(ADDR_SRC_RD, d); check("R2 src rd wrap", d, 1);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    bus_wr(ADDR_SRC_WR, 1);  // advance 14 > space 13
    bus_rd(ADDR_SRC_WR, d); check("R4 src ovf ignored", d, 3);
    bus_rd(ADDR_MISC_IS, d); check("R4 src ovf flag", d, 32'h20);
    bus_wr(ADDR_SRC_WR, 0);  // advance 13 == space: accepted, ring full
    bus_rd(ADDR_SRC_WR, d); check("R4 src fill to full", d, 0);
    consume_src(15);
    bus_rd(ADDR_SRC_RD, d); check("R2 src drain", d, 0);
    bus_wr(ADDR_DST_WR, 7);
    bus_rd(ADDR_DST_WR, d); check("R2 dst wr", d, 7);
    bus_wr(ADDR_DST_WR, 0);
    bus_rd(ADDR_DST_WR, d); check("R4 dst ovf ignored", d, 7);
    bus_rd(ADDR_MISC_IS, d); check("R4 dst ovf flag", d, 32'h60);
    consume_dst(2);
    bus_rd(ADDR_DST_RD, d); check("R2 dst rd", d, 2);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    bus_wr(ADDR_MISC_IS, 0);
    bus_rd(ADDR_MISC_IS, d); check("R7 write 0 keeps", d, 32'h60);
    bus_wr(ADDR_MISC_IS, 32'h20);
    bus_rd(ADDR_MISC_IS, d); check("R7 clear one bit", d, 32'h40);
    bus_wr(ADDR_MISC_IS, 32'h40);
    bus_rd(ADDR_MISC_IS, d); check("R7 clear other", d, 0);
  endtask

  task automatic t_fault;
    logic [31:0] d;
    pulse_fault(4'b1001);
    bus_rd(ADDR_MISC_IS, d); check("R9 faults 0,3", d, 32'h480);
    pulse_fault(4'b0110);
    bus_rd(ADDR_MISC_IS, d); check("R9 faults 1,2", d, 32'h780);
    bus_wr(ADDR_MISC_IS, 32'h780);
    bus_rd(ADDR_MISC_IS, d); check("R9 cleared", d, 0);
  endtask

  task automatic t_irq;
    @(negedge clk); check("R8 no enable", 32'(irq), 0);
    bus_wr(ADDR_MISC_IE, 32'h400);
    @(negedge clk); check("R8 enable no status", 32'(irq), 0);
    pulse_fault(4'b1000);
    check("R8 misc irq", 32'(irq), 1);
    bus_wr(ADDR_MISC_IS, 32'h400);
    @(negedge clk); check("R8 misc cleared", 32'(irq), 0);
    bus_wr(ADDR_HOST_IE, 32'h08);  // dst fill 5 > threshold 0
    @(negedge clk); check("R8 host irq", 32'(irq), 1);
    bus_wr(ADDR_HOST_IE, 0);
    bus_wr(ADDR_MISC_IE, 0);
    @(negedge clk); check("R8 disabled", 32'(irq), 0);
  endtask

  task automatic t_ro;
    logic [31:0] d;
    bus_wr(ADDR_SRC_RD, 7);
    bus_rd(ADDR_SRC_RD, d); check("R12 src rd ro", d, 0);
    bus_wr(ADDR_DST_RD, 7);
    bus_rd(ADDR_DST_RD, d); check("R12 dst rd ro", d, 2);
  endtask

  task automatic t_wm;
    logic [31:0] d;
    bus_wr(ADDR_SRC_WM, {16'd0, 16'd3});
    bus_rd(ADDR_SRC_WM, d); check("R6 wm readback", d, 32'h3);
    bus_wr(ADDR_SRC_WR, 3);
    idle(1);
    bus_wr(ADDR_HOST_IS, 32'h1F);
    idle(1);
    bus_rd(ADDR_HOST_IS, d); check("R6 fill == hi no flag", d & 2, 0);
    bus_wr(ADDR_SRC_WR, 4);
    idle(1);
    bus_rd(ADDR_HOST_IS, d); check("R6 src hi", d & 2, 2);
    bus_wr(ADDR_SRC_WM, {16'd2, 16'd15});
    bus_wr(ADDR_HOST_IS, 32'h1F);
    idle(1);
    bus_rd(ADDR_HOST_IS, d); check("R6 fill >= lo no flag", d & 4, 0);
    consume_src(3);
    idle(1);
    bus_rd(ADDR_HOST_IS, d); check("R6 src lo", d & 4, 4);
    bus_wr(ADDR_DST_WM, {16'd6, 16'd5});
    bus_wr(ADDR_HOST_IS, 32'h1F);
    idle(1);
    bus_rd(ADDR_HOST_IS, d); check("R6 dst lo not hi", d & 32'h18, 32'h10);
  endtask

  task automatic t_halt;
    logic [31:0] d;
    @(negedge clk) busy = 1'b1;
    bus_wr(ADDR_CMD, 1);
    idle(2);
    bus_rd(ADDR_CMD, d); check("R10 busy holds off", d, 1);
    @(negedge clk) busy = 1'b0;
    @(negedge clk); check("R10 halted", 32'(halted), 1);
    bus_rd(ADDR_CMD, d); check("R10 status bit", d, 9);
    consume_src(1);
    bus_rd(ADDR_SRC_RD, d); check("R11 consume frozen", d, 3);
    bus_wr(ADDR_CMD, 0);
    check("R10 still halted", 32'(halted), 1);
    idle(1);
    @(negedge clk); check("R10 release", 32'(halted), 0);
    consume_src(1);
    bus_rd(ADDR_SRC_RD, d); check("R11 resumes", d, 4);
  endtask

  initial begin
    #(200000 * 10);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_src_ring();
    t_overflow();
    t_w1c();
    t_fault();
    t_irq();
    t_ro();
    t_wm();
    t_halt();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule